// File: doc/BRIEF.md
# Reconfigurable Phase-Shifted Carrier Modulator

This block produces the insert/bypass pattern for one leg of a multilevel converter built from two arms of identical submodules. Every submodule owns a triangular carrier, and the carriers of an arm are spread evenly over one carrier period. A signed modulation sample sets two complementary arm references. A submodule is inserted while its arm reference lies above its own carrier, so the number of inserted cells in each arm follows the sample.

Submodules in the upper arm can be flagged as faulty. A flagged cell is pulled out of service at once and stays out until reset. At the next carrier valley the surviving upper-arm carriers are spread evenly again over the smaller group. The lower arm keeps its full-pool spacing, so after a fault the two arms run with different carrier sets on purpose. The carrier half-period can be reprogrammed through a load strobe, and the new value also takes effect at the next valley. An output reports how many upper-arm cells are currently in the rotation.

Top module: `pscpwm`

## Requirements
- R1: While reset is held and after it is released, the carrier half-period P equals the parameter DEF_HALF, no cell is flagged, the reported active count equals NSM, and the phase time t (counted from the last valley) is 0.
- R2: Each carrier value is tri(x) = x when x <= P and 2P - x otherwise, where x = (t + offset) mod 2P. t advances by one per clock and returns to 0 in the clock after it reaches 2P - 1. That return is the valley.
- R3: Lower-arm cell k (k = 0..NSM-1) uses offset (floor(k*2P/NSM) + P) mod 2P at all times, half a carrier period from the full-pool upper-arm slot of the same index.
- R4: Healthy upper-arm cells are ranked 0,1,2,... in ascending index order. A cell of rank r uses offset floor(r*2P/n), where n is the number of healthy cells applied at the last valley.
- R5: With the sample s clamped to [-P, P], the upper reference is floor((P - s)/2) and the lower reference is floor((P + s)/2). A gate bit is 1 exactly when its arm reference is strictly greater than its carrier.
- R6: A 1 on fault bit i forces upper gate bit i to 0 in the same cycle and in every later cycle until reset, even if the fault bit is deasserted afterwards.
- R7: Respacing after a fault happens only at a valley. A fault that is present in the cycle when t = 2P - 1 is included in that valley's respacing.
- R8: A load strobe captures the half-period input, with 0 taken as 1. The captured value becomes P at the next valley, and the capture is included if the strobe falls in the valley cycle.
- R9: The active-count output equals NSM minus the number of cells applied as faulty at the last valley. It never increases until reset, and when every upper cell is faulty it reads 0 and no upper gate is ever 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mod_in | input | CW+1 | Signed modulation sample |
| fault_in | input | NSM | Upper-arm fault flags, one per cell |
| half_in | input | CW | Carrier half-period to load |
| load | input | 1 | Strobe that captures half_in |
| gate_up | output | NSM | Upper-arm insert bits |
| gate_lo | output | NSM | Lower-arm insert bits |
| n_active | output | $clog2(NSM+1) | Healthy upper cells in rotation |

## Verification
The hardest case to reach is a fault that arrives in the exact cycle that precedes a valley. In that cycle the cell must be blocked at once, and the respacing must already count it. The stimulus reaches this case by following the reference model's phase time and raising a single-cycle fault pulse only when that time reaches 2P - 1. Two other cases also get dedicated stimulus. A half-period of 0 drives the carrier to its smallest period, and a full fault mask drives the active count to 0, which exercises the divide-by-zero guard on the offsets.

// File: rtl/pscpwm.sv
module pscpwm #(
  parameter int NSM      = 5,
  parameter int CW       = 16,
  parameter int DEF_HALF = 50000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic signed [CW:0] mod_in,
  input  logic [NSM-1:0]    fault_in,
  input  logic [CW-1:0]     half_in,
  input  logic              load,
  output logic [NSM-1:0]    gate_up,
  output logic [NSM-1:0]    gate_lo,
  output logic [$clog2(NSM+1)-1:0] n_active
);
  localparam int PW = CW + 1;
  localparam int NW = $clog2(NSM + 1);
  localparam logic [CW-1:0] PDEF = CW'(DEF_HALF);

  function automatic logic [PW-1:0] tri_f(input logic [PW-1:0] ph, input logic [CW-1:0] p);
    return (ph <= {1'b0, p}) ? ph : ({p, 1'b0} - ph);
  endfunction

  function automatic logic [PW-1:0] up_off(input int rank, input int n, input int p);
    return (n == 0) ? '0 : PW'((rank * 2 * p) / n);
  endfunction

  function automatic logic [PW-1:0] lo_off(input int k, input int p);
    int v;
    v = (k * 2 * p) / NSM + p;
    if (v >= 2 * p) v = v - 2 * p;
    return PW'(v);
  endfunction

  logic [CW-1:0]  p_act, p_pend;
  logic [NSM-1:0] dead, used;
  logic [PW-1:0]  ph_ref;
  logic [PW-1:0]  ph_up [NSM];
  logic [PW-1:0]  ph_lo [NSM];

  wire [PW-1:0]  two_p   = {p_act, 1'b0};
  wire           valley  = (ph_ref == two_p - 1'b1);
  wire [NSM-1:0] dead_nx = dead | fault_in;
  wire [CW-1:0]  p_nx    = load ? ((half_in == '0) ? CW'(1) : half_in) : p_pend;

  int rank_nx [NSM];
  int n_nx;
  always_comb begin
    int r;
    r = 0;
    for (int i = 0; i < NSM; i++) begin
      rank_nx[i] = r;
      if (!dead_nx[i]) r = r + 1;
    end
    n_nx = r;
  end

  always_comb begin
    int c;
    c = 0;
    for (int i = 0; i < NSM; i++) if (!used[i]) c = c + 1;
    n_active = NW'(c);
  end

  logic signed [CW+1:0] m_ext, p_sg, m_cl, r_up, r_lo;
  assign m_ext = {mod_in[CW], mod_in};
  assign p_sg  = {2'b00, p_act};
  assign m_cl  = (m_ext > p_sg) ? p_sg : ((m_ext < -p_sg) ? -p_sg : m_ext);
  assign r_up  = (p_sg - m_cl) >>> 1;
  assign r_lo  = (p_sg + m_cl) >>> 1;

  always_comb begin
    for (int i = 0; i < NSM; i++) begin
      gate_up[i] = !dead_nx[i] && (r_up > $signed({1'b0, tri_f(ph_up[i], p_act)}));
      gate_lo[i] = (r_lo > $signed({1'b0, tri_f(ph_lo[i], p_act)}));
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      p_act  <= PDEF;
      p_pend <= PDEF;
      dead   <= '0;
      used   <= '0;
      ph_ref <= '0;
      for (int i = 0; i < NSM; i++) begin
        ph_up[i] <= up_off(i, NSM, DEF_HALF);
        ph_lo[i] <= lo_off(i, DEF_HALF);
      end
    end else begin
      dead   <= dead_nx;
      p_pend <= p_nx;
      if (valley) begin
        p_act  <= p_nx;
        used   <= dead_nx;
        ph_ref <= '0;
        for (int i = 0; i < NSM; i++) begin
          ph_up[i] <= dead_nx[i] ? '0 : up_off(rank_nx[i], n_nx, int'(p_nx));
          ph_lo[i] <= lo_off(i, int'(p_nx));
        end
      end else begin
        ph_ref <= ph_ref + 1'b1;
        for (int i = 0; i < NSM; i++) begin
          ph_up[i] <= (ph_up[i] == two_p - 1'b1) ? '0 : ph_up[i] + 1'b1;
          ph_lo[i] <= (ph_lo[i] == two_p - 1'b1) ? '0 : ph_lo[i] + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/pscpwm_chk.sv
module pscpwm_chk #(
  parameter int NSM = 5,
  parameter int NW  = 3
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NSM-1:0] fault_in,
  input logic [NSM-1:0] gate_up,
  input logic [NW-1:0]  n_active
);
  logic [NSM-1:0] seen;
  always_ff @(posedge clk) begin
    if (!rst_n) seen <= '0;
    else        seen <= seen | fault_in;
  end

  for (genvar i = 0; i < NSM; i++) begin : g_sticky
    a_r6_sticky_bypass: assert property (@(posedge clk) disable iff (!rst_n)
      seen[i] |-> !gate_up[i]);
  end

  a_r9_count_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
    n_active <= $past(n_active));

  a_r9_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    int'(n_active) <= NSM);

  a_r4_gates_within_count: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(gate_up) <= int'(n_active));
endmodule

bind pscpwm pscpwm_chk #(.NSM(NSM), .NW($clog2(NSM+1))) u_chk (
  .clk(clk), .rst_n(rst_n), .fault_in(fault_in), .gate_up(gate_up), .n_active(n_active)
);

// File: tb/pscpwm_tb.sv
module pscpwm_tb;
  localparam int NSM = 5;
  localparam int CW = 12;
  localparam int DEF = 30;
  localparam int CLK_PERIOD = 10;

  logic clk = 0;
  logic rst_n = 0;
  logic signed [CW:0] mod_in = '0;
  logic [NSM-1:0] fault_in = '0;
  logic [CW-1:0] half_in = '0;
  logic load = 0;
  logic [NSM-1:0] gate_up, gate_lo;
  logic [2:0] n_active;

  pscpwm #(.NSM(NSM), .CW(CW), .DEF_HALF(DEF)) u_dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  int t = 0, pa = DEF, pp = DEF;
  bit [NSM-1:0] mdead = '0, mapp = '0;

  function automatic int trif(int x, int p);
    return (x <= p) ? x : 2 * p - x;
  endfunction

  task automatic check();
    int ms, ru, rl, n, r;
    bit [NSM-1:0] eu, el;
    bit [NSM-1:0] live;
    ms = int'(mod_in);
    if (ms > pa) ms = pa;
    if (ms < -pa) ms = -pa;
    ru = (pa - ms) / 2;
    rl = (pa + ms) / 2;
    live = mdead | fault_in;
    n = 0;
    for (int i = 0; i < NSM; i++) if (!mapp[i]) n++;
    r = 0;
    for (int i = 0; i < NSM; i++) begin
      // R2 R4 R5 R6: upper arm
      if (live[i]) eu[i] = 0;
      else eu[i] = ru > trif((t + (n == 0 ? 0 : (r * 2 * pa) / n)) % (2 * pa), pa);
      if (!mapp[i]) r++;
      // R3 R5: lower arm
      el[i] = rl > trif((t + (i * 2 * pa) / NSM + pa) % (2 * pa), pa);
    end
    n_chk += 3;
    if (gate_up !== eu) begin
      n_bad++;
      $display("FAIL R4/R6 upper gates t=%0d: got %b exp %b", t, gate_up, eu);
    end
    if (gate_lo !== el) begin
      n_bad++;
      $display("FAIL R3/R5 lower gates t=%0d: got %b exp %b", t, gate_lo, el);
    end
    if (int'(n_active) != n) begin
      n_bad++;
      $display("FAIL R9 active count: got %0d exp %0d", n_active, n);
    end
  endtask

  // R7 R8: state advance
  task automatic model_step();
    bit [NSM-1:0] dn;
    int pn;
    dn = mdead | fault_in;
    pn = load ? ((half_in == 0) ? 1 : int'(half_in)) : pp;
    if (t == 2 * pa - 1) begin
      t = 0;
      pa = pn;
      mapp = dn;
    end else t++;
    mdead = dn;
    pp = pn;
  endtask

  task automatic tick(int cnt);
    for (int k = 0; k < cnt; k++) begin
      #1 check();
      @(posedge clk);
      model_step();
      @(negedge clk);
    end
  endtask

  task automatic run_mod(int cnt, int step);
    for (int k = 0; k < cnt; k++) begin
      mod_in = (CW+1)'((k * step) % 81 - 40);
      tick(1);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1 check(); // R1: reset state
    @(negedge clk);
    rst_n = 1;
    run_mod(300, 7);                         // R2 R3 R5 normal, clamp
    half_in = 12'd40; load = 1; tick(1); load = 0;   // R8
    run_mod(250, 11);
    fault_in = 5'b00100; tick(1); fault_in = '0;     // R6 R7
    run_mod(300, 3);
    while (t != 2 * pa - 1) tick(1);
    fault_in = 5'b00001; tick(1); fault_in = '0;     // R7 fault at valley cycle
    run_mod(300, 13);
    half_in = 12'd0; load = 1; tick(1); load = 0;    // R8 zero taken as one
    run_mod(100, 5);
    while (t != 2 * pa - 1) tick(1);
    half_in = 12'd25; load = 1; tick(1); load = 0;   // R8 load at valley
    run_mod(200, 9);
    fault_in = 5'b11111; tick(1); fault_in = '0;     // R9 all faulty
    run_mod(200, 17);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule